// File: doc/BRIEF.md
# Daisy-Chain Serial Register Sequencer

This block sits on the host side of a chain of identical serial peripherals, each of which holds a 24-bit shift frame. A single command names a chain position and either a frame to write or a register to read. The block turns that command into gated serial clock bursts, serial data and a latch strobe. Every burst carries exactly one frame for each device in the chain. The addressed position gets the payload and every other position gets an all-zero no-operation frame.

A read takes two transfers. The first carries a read-select frame to the addressed device. The second carries no-operation frames to the whole chain, and while it runs the block samples the returned serial data. The bits that belong to devices further down the chain are skipped, and the addressed device's 24 bits are delivered on a response port with a one-cycle valid strobe.

Top module: `serial_chain_ctrl`

## Requirements
- R1: After reset, cmd_ready is 1 and sclk, latch, sdin and rsp_valid are all 0.
- R2: A write (cmd_read=0) produces one burst of N_DEV*24 bits, MSB first. The chain slot for position N_DEV-1 is sent first, so position p occupies stream bits [p*24 +: 24]. That slot carries cmd_data and every other slot is zero. One latch pulse follows the burst.
- R3: Each burst has exactly N_DEV*24 rising sclk edges before latch rises. latch stays low during the burst and stays high for 2*HALF system clocks, which is one sclk period.
- R4: sclk has a period of 2*HALF system clocks, with HALF cycles high and HALF cycles low. sdin changes only while sclk is low.
- R5: A read (cmd_read=1) first sends a burst whose slot for cmd_pos holds {8'h02, 14'b0, cmd_data[1:0]}, with all other slots zero, and latches it. It then sends an all-zero burst and latches that. The code in cmd_data[1:0] selects the register: 00 status, 01 data, 10 control.
- R6: During the second burst of a read, sdo is sampled on each rising sclk. The first (N_DEV-1-cmd_pos)*24 bits are discarded, and the next 24 bits, MSB first, become rsp_data.
- R7: rsp_valid is a one-cycle pulse in the cycle in which latch falls at the end of the second read burst. rsp_data holds its value until the next read completes.
- R8: cmd_ready is low from the cycle after a command is accepted until latch falls at the end of the last burst of that command. A command presented while cmd_ready is low has no effect.
- R9: A write produces no rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_read | input | 1 | 1 = register read, 0 = frame write |
| cmd_pos | input | KW | Chain position of the target device |
| cmd_data | input | 24 | Write frame, or read register code in bits 1:0 |
| rsp_valid | output | 1 | Read result strobe |
| rsp_data | output | 24 | Read result |
| sclk | output | 1 | Gated serial clock |
| sdin | output | 1 | Serial data to the chain |
| latch | output | 1 | Transfer latch strobe |
| sdo | input | 1 | Serial data returned from the chain |

## Verification
The bench builds the block with N_DEV=3 and HALF=2. Three positions give a nonzero discard count for the nearest and middle devices, and zero discard for the far end. With two cycles per sclk phase, the period and latch-width checks can tell a correct divider from an off-by-one one. A bench-side chain of three register models answers the read-selects, so every register code and every position returns a value that only correct slot placement and correct bit alignment can deliver.

// File: rtl/serial_chain_ctrl.sv
module serial_chain_ctrl #(
  parameter int N_DEV = 4,
  parameter int HALF  = 4,
  parameter int KW    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_read,
  input  logic [KW-1:0] cmd_pos,
  input  logic [23:0]   cmd_data,
  output logic          rsp_valid,
  output logic [23:0]   rsp_data,
  output logic          sclk,
  output logic          sdin,
  output logic          latch,
  input  logic          sdo
);
  localparam int FW    = 24;
  localparam int TOTAL = N_DEV * FW;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int DW    = $clog2(2 * HALF + 1);

  typedef enum logic [1:0] {IDLE, LOW, HIGH, LAT} st_t;

  st_t             st;
  logic [TOTAL-1:0] sr;
  logic [CW-1:0]   bitc, lim;
  logic [DW-1:0]   divc;
  logic            rd, sel;
  logic [FW-1:0]   cap;

  function automatic logic [TOTAL-1:0] place(logic [FW-1:0] f, logic [KW-1:0] k);
    return TOTAL'(f) << (FW * k);
  endfunction

  wire half_end = divc == DW'(HALF - 1);
  wire lat_end  = divc == DW'(2 * HALF - 1);
  wire last_bit = bitc == CW'(TOTAL - 1);

  assign cmd_ready = st == IDLE;
  assign sclk      = st == HIGH;
  assign latch     = st == LAT;
  assign sdin      = (st == LOW || st == HIGH) && sr[TOTAL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      sr        <= '0;
      bitc      <= '0;
      lim       <= '0;
      divc      <= '0;
      rd        <= 1'b0;
      sel       <= 1'b0;
      cap       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        IDLE: if (cmd_valid) begin
          rd   <= cmd_read;
          sel  <= cmd_read;
          lim  <= CW'((N_DEV - int'(cmd_pos)) * FW);
          sr   <= place(cmd_read ? {8'h02, 14'd0, cmd_data[1:0]} : cmd_data, cmd_pos);
          bitc <= '0;
          divc <= '0;
          st   <= LOW;
        end
        LOW: if (half_end) begin
          divc <= '0;
          st   <= HIGH;
          if (rd && !sel && bitc < lim) cap <= {cap[FW-2:0], sdo};
        end else divc <= divc + 1'b1;
        HIGH: if (half_end) begin
          divc <= '0;
          sr   <= sr << 1;
          if (last_bit) st <= LAT;
          else begin
            bitc <= bitc + 1'b1;
            st   <= LOW;
          end
        end else divc <= divc + 1'b1;
        LAT: if (lat_end) begin
          divc <= '0;
          if (sel) begin
            sel  <= 1'b0;
            sr   <= '0;
            bitc <= '0;
            st   <= LOW;
          end else begin
            st <= IDLE;
            if (rd) begin
              rsp_valid <= 1'b1;
              rsp_data  <= cap;
            end
          end
        end else divc <= divc + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  logic          sclk_q;
  logic [CW-1:0] rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_q <= sclk;
      if (latch) rises <= '0;
      else if (sclk && !sclk_q) rises <= rises + 1'b1;
    end
  end

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> rises == CW'(TOTAL));

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_rsp_after_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $fell(latch));

  assert_sdin_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdin));
endmodule

// File: tb/test_serial_chain_ctrl.sv
module test_serial_chain_ctrl;
  localparam int N  = 3;
  localparam int H  = 2;
  localparam int FW = 24;
  localparam int T  = N * FW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [1:0] cmd_pos = '0;
  logic [23:0] cmd_data = '0;
  logic cmd_ready, rsp_valid, sclk, sdin, latch, sdo;
  logic [23:0] rsp_data;

  serial_chain_ctrl #(.N_DEV(N), .HALF(H)) i_serial_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_pos(cmd_pos), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sclk(sclk), .sdin(sdin),
    .latch(latch), .sdo(sdo));

  int nchk = 0, nerr = 0;
  task automatic chk(bit ok, string req, logic [T-1:0] act, logic [T-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [T-1:0] slot(logic [23:0] f, logic [1:0] p);
    return T'(f) << (FW * p);
  endfunction

  // bench-side chain of register models
  logic [T-1:0] rx = '0, tx = '0;
  logic [23:0]  dreg [N];
  logic [T-1:0] lat_log [2];
  logic sclk_q = 0, latch_q = 0, sdin_q = 0, rsp_q = 0;
  int lat_n = 0, rsp_n = 0, rises = 0, per = 0, hi_len = 0, lat_len = 0;
  int bad_rises = 0, bad_lat = 0, bad_per = 0, bad_hi = 0, bad_sdin = 0, bad_rsp = 0, bad_rdy = 0;
  assign sdo = tx[T-1];

  initial for (int d = 0; d < N; d++) dreg[d] = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      rises = 0; per = 0; hi_len = 0; lat_len = 0;
      sclk_q = 0; latch_q = 0; sdin_q = 0; rsp_q = 0;
    end else begin
      per++;
      if (sclk && !sclk_q) begin
        rx = {rx[T-2:0], sdin};
        if (rises > 0 && per != 2 * H) bad_per++;
        per = 0;
        rises++;
      end
      if (!sclk && sclk_q) begin
        tx = tx << 1;
        if (hi_len != H) bad_hi++;
        hi_len = 0;
      end
      if (sclk) hi_len++;
      if (sclk && sclk_q && sdin != sdin_q) bad_sdin++;
      if (cmd_ready && (sclk || latch)) bad_rdy++;
      if (latch) lat_len++;
      if (!latch && latch_q) begin
        if (lat_len != 2 * H) bad_lat++;
        lat_len = 0;
      end
      if (latch && !latch_q) begin
        if (rises != T) bad_rises++;
        rises = 0;
        if (lat_n < 2) lat_log[lat_n] = rx;
        lat_n++;
        for (int d = 0; d < N; d++) begin
          logic [23:0] f;
          f = rx[d*FW +: FW];
          if (f[23:16] == 8'h02)
            tx[d*FW +: FW] = (f[1:0] == 2'b00) ? (24'h00A500 ^ 24'(d)) :
                             (f[1:0] == 2'b01) ? dreg[d] : (24'h0C0000 + 24'(d));
          else begin
            tx[d*FW +: FW] = '0;
            if (f != 0) dreg[d] = f;
          end
        end
      end
      if (rsp_valid) begin
        rsp_n++;
        if (!(latch_q && !latch) || rsp_q) bad_rsp++;
      end
      sclk_q = sclk; latch_q = latch; sdin_q = sdin; rsp_q = rsp_valid;
    end
  end

  task automatic present(bit rd, logic [1:0] pos, logic [23:0] data);
    @(negedge clk);
    lat_n = 0; rsp_n = 0;
    cmd_valid = 1; cmd_read = rd; cmd_pos = pos; cmd_data = data;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic finish_op();
    while (!(cmd_ready && !latch)) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // {read, pos, data, expected response}
  localparam logic [50:0] VEC [10] = '{
    {1'b0, 2'd0, 24'h01ABCD, 24'h000000},
    {1'b0, 2'd2, 24'h015A5A, 24'h000000},
    {1'b1, 2'd0, 24'h000001, 24'h01ABCD},
    {1'b1, 2'd2, 24'h000001, 24'h015A5A},
    {1'b1, 2'd1, 24'h000000, 24'h00A501},
    {1'b1, 2'd1, 24'h000002, 24'h0C0001},
    {1'b0, 2'd1, 24'h01FFFF, 24'h000000},
    {1'b1, 2'd1, 24'h000001, 24'h01FFFF},
    {1'b1, 2'd2, 24'h000002, 24'h0C0002},
    {1'b1, 2'd0, 24'h000000, 24'h00A500}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({cmd_ready, sclk, latch, sdin, rsp_valid} == 5'b10000, "R1",
        T'({cmd_ready, sclk, latch, sdin, rsp_valid}), T'(5'b10000));

    for (int i = 0; i < 10; i++) begin
      logic rd; logic [1:0] pos; logic [23:0] data, exp;
      {rd, pos, data, exp} = VEC[i];
      present(rd, pos, data);
      finish_op();
      if (rd) begin
        chk(lat_log[0] == slot({8'h02, 14'd0, data[1:0]}, pos), "R5 select", lat_log[0],
            slot({8'h02, 14'd0, data[1:0]}, pos));
        chk(lat_n == 2, "R5 two latches", T'(lat_n), T'(2));
        chk(lat_log[1] == '0, "R5 nop", lat_log[1], '0);
        chk(rsp_n == 1, "R7 one pulse", T'(rsp_n), T'(1));
        chk(rsp_data == exp, "R6 data", T'(rsp_data), T'(exp));
      end else begin
        chk(lat_log[0] == slot(data, pos), "R2 stream", lat_log[0], slot(data, pos));
        chk(lat_n == 1, "R2 one latch", T'(lat_n), T'(1));
        chk(rsp_n == 0, "R9 no response", T'(rsp_n), T'(0));
      end
    end

    // R7 hold: rsp_data unchanged after a write
    present(1'b0, 2'd0, 24'h01BEEF);
    finish_op();
    chk(rsp_data == 24'h00A500, "R7 hold", T'(rsp_data), T'(24'h00A500));

    // R8: command presented while busy is ignored
    present(1'b0, 2'd1, 24'h012222);
    cmd_valid = 1; cmd_read = 1; cmd_pos = 2'd0; cmd_data = 24'h000002;
    repeat (40) @(negedge clk);
    chk(cmd_ready == 0, "R8 busy", T'(cmd_ready), T'(0));
    cmd_valid = 0;
    finish_op();
    chk(lat_n == 1, "R8 single transfer", T'(lat_n), T'(1));
    chk(lat_log[0] == slot(24'h012222, 2'd1), "R8 stream", lat_log[0], slot(24'h012222, 2'd1));
    chk(rsp_n == 0, "R8 no response", T'(rsp_n), T'(0));
    present(1'b1, 2'd1, 24'h000001);
    finish_op();
    chk(rsp_data == 24'h012222, "R8 readback", T'(rsp_data), T'(24'h012222));

    // R1 reset in mid burst, then recovery
    present(1'b1, 2'd0, 24'h000001);
    repeat (30) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk({cmd_ready, sclk, latch, sdin, rsp_valid} == 5'b10000, "R1 mid reset",
        T'({cmd_ready, sclk, latch, sdin, rsp_valid}), T'(5'b10000));
    rst_n = 1;
    present(1'b1, 2'd2, 24'h000002);
    finish_op();
    chk(rsp_data == 24'h0C0002, "R6 after reset", T'(rsp_data), T'(24'h0C0002));

    chk(bad_rises == 0, "R3 clock count", T'(bad_rises), '0);
    chk(bad_lat == 0, "R3 latch width", T'(bad_lat), '0);
    chk(bad_per == 0, "R4 period", T'(bad_per), '0);
    chk(bad_hi == 0, "R4 high phase", T'(bad_hi), '0);
    chk(bad_sdin == 0, "R4 sdin stable", T'(bad_sdin), '0);
    chk(bad_rsp == 0, "R7 timing", T'(bad_rsp), '0);
    chk(bad_rdy == 0, "R8 ready", T'(bad_rdy), '0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule